// File: doc/BRIEF.md
# Status-Port Read Patching Bridge

This block sits between a 32-bit CPU bus that uses an address strobe and sized acknowledges, and an older 8-bit peripheral bus that answers with a single data-acknowledge. Most accesses pass straight through. The path to the old bus opens while the strobe is asserted, and the old bus's acknowledge goes back to the CPU.

One address is handled differently: the input-port register of the timer chip at byte offset 0x00FFFA01. A read of that address is caught. The bridge opens the old bus, lets the peripheral answer, and keeps that answer away from the CPU. It latches the returned byte and closes the old-bus path. It then clears data bit 5 whenever an external disk-controller interrupt is active. The interrupt line is active high, while the status bit is active low. Only after this does the bridge acknowledge the CPU as an 8-bit port.

Every other bit of the byte is the live value from the peripheral. If the peripheral never answers, a cycle counter ends the access with a bus error.

Top module: `stat_patch_bridge`

## Requirements
- R1: A read is intercepted when the address is 0x00FFFA01 or its sign-extended alias 0xFFFFFA01. Any other top byte, for example 0x01FFFA01, is not intercepted. In the first cycle of an intercepted access `obus_en` is low.
- R2: A write to the intercepted address passes through. `obus_en` is high while the strobe is low, and `cpu_dsack_n` equals {1, `obus_dtack_n`}.
- R3: With the bridge idle, any non-intercepted access asserts `obus_en` while `cpu_as_n` is low and drives `cpu_dsack_n` = {1'b1, `obus_dtack_n`}. With the strobe high, `cpu_dsack_n` is 2'b11.
- R4: While an intercepted read waits on the old bus, `obus_en` is 1 and `cpu_dsack_n` stays 2'b11, whatever `obus_dtack_n` does.
- R5: On the clock edge that sees `obus_dtack_n` low during an intercepted read, the bridge captures `obus_data`. From the next cycle `obus_en` is 0 and `cpu_dsack_n` is 2'b10, the 8-bit-port code (bit 0 low, bit 1 high).
- R6: During that acknowledge phase `cpu_data_oe` is 1. The byte appears on `cpu_data_o[31:24]` and `cpu_data_o[23:0]` is zero. At all other times `cpu_data_oe` is 0 and `cpu_data_o` is zero.
- R7: Bit 5 of the returned byte is the captured bit 5 ANDed with the inverted synchronised interrupt. Bits 7..6 and 4..0 equal the captured byte.
- R8: `ide_irq` passes through a two-flop synchroniser. The value used is the one sampled two edges before the capture edge, so a change made in the cycle just before capture has no effect on the byte.
- R9: If `obus_dtack_n` stays high for 16 cycles (parameter `TMO_CYC`) of an intercepted read, `cpu_berr_n` goes low and `obus_en` goes low. Both stay that way until the strobe is negated.
- R10: When `cpu_as_n` goes high, the bridge returns to idle on that edge. This releases `cpu_dsack_n`, `cpu_data_oe` and `cpu_berr_n`, and also abandons a read still waiting on the old bus.
- R11: While `rst_n` is low, `obus_en` is 0, `cpu_dsack_n` is 2'b11, `cpu_berr_n` is 1 and `cpu_data_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_as_n | input | 1 | CPU address strobe, active low |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_addr | input | 32 | CPU byte address |
| cpu_dsack_n | output | 2 | Sized acknowledge to the CPU, active low |
| cpu_berr_n | output | 1 | Bus error to the CPU, active low |
| cpu_data_oe | output | 1 | Bridge drives the CPU data bus |
| cpu_data_o | output | 32 | Data toward the CPU (patched byte in bits 31:24) |
| obus_en | output | 1 | Opens the path to the old bus |
| obus_dtack_n | input | 1 | Old-bus data acknowledge, active low |
| obus_data | input | 8 | Byte returned by the old bus |
| ide_irq | input | 1 | Asynchronous disk-controller interrupt, active high |

## Verification
Intercepted reads are driven with several byte values. Bytes with bit 5 already low show that the interrupt is ANDed in rather than substituted. All-ones and mixed bytes show that the other bits come from the peripheral and are not constants. Both address aliases are tried against a near-miss top byte and against a write to the same address, which separates the decode from the direction check. The interrupt is also toggled in the cycle just before capture, to show the synchroniser latency. A silent peripheral and an early strobe negation cover the timeout and abort exits. A behavioural state model in the bench predicts every output on every cycle.

// File: rtl/spb_pkg.sv
package spb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_HOLD  = 2'd2,
    ST_BERR  = 2'd3
  } spb_state_e;

  // Map the sign-extended alias (top byte all ones) onto the zero-based form.
  function automatic logic [31:0] fold_alias(input logic [31:0] a);
    logic [31:0] r;
    r = a;
    if (a[31:24] == 8'hFF) r[31:24] = 8'h00;
    return r;
  endfunction

  // Clear one active-low status bit when the foreign interrupt is active.
  function automatic logic [7:0] splice_irq(input logic [7:0] raw,
                                            input logic irq,
                                            input int unsigned pos);
    logic [7:0] r;
    r = raw;
    r[pos] = raw[pos] & ~irq;
    return r;
  endfunction

endpackage

// File: rtl/spb_sync.sv
module spb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d_async;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/spb_decode.sv
module spb_decode
  import spb_pkg::*;
#(
  parameter logic [31:0] MATCH_ADDR = 32'h00FF_FA01
) (
  input  logic [31:0] addr,
  input  logic        rw,
  output logic        hit
);
  always_comb hit = rw && (fold_alias(addr) == MATCH_ADDR);
endmodule

// File: rtl/spb_seq.sv
module spb_seq
  import spb_pkg::*;
#(
  parameter int          TMO_CYC   = 16,
  parameter int          BYTE_W    = 8,
  parameter int unsigned PATCH_BIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              as_n,
  input  logic              hit,
  input  logic              dtack_n,
  input  logic [BYTE_W-1:0] old_data,
  input  logic              irq_sync,
  output spb_state_e        state,
  output logic [BYTE_W-1:0] cap_byte,
  output logic              irq_cap,
  output logic              ev_capture,
  output logic              ev_timeout
);
  localparam int CNT_W = (TMO_CYC > 2) ? $clog2(TMO_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TMO_CYC - 1);

  logic [CNT_W-1:0] cnt;

  assign ev_capture = (state == ST_FETCH) && !as_n && !dtack_n;
  assign ev_timeout = (state == ST_FETCH) && !as_n && dtack_n && (cnt == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      cap_byte <= '0;
      irq_cap  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (!as_n && hit) state <= ST_FETCH;
        end
        ST_FETCH: begin
          if (as_n) begin
            state <= ST_IDLE;
          end else if (ev_capture) begin
            state    <= ST_HOLD;
            cap_byte <= splice_irq(old_data, irq_sync, PATCH_BIT);
            irq_cap  <= irq_sync;
          end else if (ev_timeout) begin
            state <= ST_BERR;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_HOLD, ST_BERR: begin
          if (as_n) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stat_patch_bridge.sv
module stat_patch_bridge
  import spb_pkg::*;
#(
  parameter logic [31:0] MATCH_ADDR = 32'h00FF_FA01,
  parameter int          TMO_CYC    = 16,
  parameter int          DATA_W     = 32,
  parameter int          BYTE_W     = 8,
  parameter int unsigned PATCH_BIT  = 5,
  parameter int          SYNC_STG   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_as_n,
  input  logic              cpu_rw,
  input  logic [31:0]       cpu_addr,
  output logic [1:0]        cpu_dsack_n,
  output logic              cpu_berr_n,
  output logic              cpu_data_oe,
  output logic [DATA_W-1:0] cpu_data_o,
  output logic              obus_en,
  input  logic              obus_dtack_n,
  input  logic [BYTE_W-1:0] obus_data,
  input  logic              ide_irq
);
  localparam int LOW_W = DATA_W - BYTE_W;
  localparam logic [1:0] ACK_NONE  = 2'b11;
  localparam logic [1:0] ACK_PORT8 = 2'b10;

  logic              hit;
  logic              irq_sync;
  logic              irq_cap;
  logic              ev_capture;
  logic              ev_timeout;
  logic              pass_cyc;
  spb_state_e        state;
  logic [BYTE_W-1:0] cap_byte;

  spb_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(ide_irq), .q_sync(irq_sync)
  );

  spb_decode #(.MATCH_ADDR(MATCH_ADDR)) u_decode (
    .addr(cpu_addr), .rw(cpu_rw), .hit(hit)
  );

  spb_seq #(.TMO_CYC(TMO_CYC), .BYTE_W(BYTE_W), .PATCH_BIT(PATCH_BIT)) u_seq (
    .clk(clk), .rst_n(rst_n), .as_n(cpu_as_n), .hit(hit),
    .dtack_n(obus_dtack_n), .old_data(obus_data), .irq_sync(irq_sync),
    .state(state), .cap_byte(cap_byte), .irq_cap(irq_cap),
    .ev_capture(ev_capture), .ev_timeout(ev_timeout)
  );

  assign pass_cyc = (state == ST_IDLE) && !cpu_as_n && !hit;

  always_comb begin
    obus_en     = pass_cyc || (state == ST_FETCH);
    cpu_berr_n  = (state != ST_BERR);
    cpu_data_oe = (state == ST_HOLD);
    if (pass_cyc)               cpu_dsack_n = {1'b1, obus_dtack_n};
    else if (state == ST_HOLD)  cpu_dsack_n = ACK_PORT8;
    else                        cpu_dsack_n = ACK_NONE;
    cpu_data_o = cpu_data_oe ? {cap_byte, {LOW_W{1'b0}}} : '0;
  end
endmodule

// File: rtl/stat_patch_bridge_chk.sv
module stat_patch_bridge_chk
  import spb_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_as_n,
  input logic        cpu_rw,
  input logic [1:0]  cpu_dsack_n,
  input logic        cpu_berr_n,
  input logic        cpu_data_oe,
  input logic [31:0] cpu_data_o,
  input logic        obus_en,
  input logic        irq_cap,
  input spb_state_e  state
);
  AST_FETCH_HIDES_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FETCH) |-> (cpu_dsack_n == 2'b11 && obus_en)); // R4
  AST_PORT8_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_data_oe |-> (cpu_dsack_n == 2'b10 && !obus_en)); // R5
  AST_LOW_LANES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_data_o[23:0] == 24'h0); // R6
  AST_BIT5_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_data_oe && irq_cap) |-> !cpu_data_o[29]); // R7
  AST_BERR_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_berr_n) |-> $past(state == ST_FETCH)); // R9
  AST_BERR_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_berr_n |-> (!obus_en && !cpu_data_oe)); // R9
  AST_RELEASE_ON_AS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_as_n) |=> (!cpu_data_oe && cpu_berr_n)); // R10
  AST_WRITE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_as_n && !cpu_rw && state == ST_IDLE) |-> obus_en); // R2
endmodule

bind stat_patch_bridge stat_patch_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_as_n(cpu_as_n), .cpu_rw(cpu_rw),
  .cpu_dsack_n(cpu_dsack_n), .cpu_berr_n(cpu_berr_n),
  .cpu_data_oe(cpu_data_oe), .cpu_data_o(cpu_data_o), .obus_en(obus_en),
  .irq_cap(irq_cap), .state(state)
);

// File: tb/test_stat_patch_bridge.sv
module test_stat_patch_bridge;
  localparam int TMO = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_as_n = 1'b1;
  logic        cpu_rw = 1'b1;
  logic [31:0] cpu_addr = 32'h0;
  logic [1:0]  cpu_dsack_n;
  logic        cpu_berr_n;
  logic        cpu_data_oe;
  logic [31:0] cpu_data_o;
  logic        obus_en;
  logic        obus_dtack_n = 1'b1;
  logic [7:0]  obus_data = 8'h00;
  logic        ide_irq = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  stat_patch_bridge #(.TMO_CYC(TMO)) i_stat_patch_bridge (
    .clk(clk), .rst_n(rst_n), .cpu_as_n(cpu_as_n), .cpu_rw(cpu_rw),
    .cpu_addr(cpu_addr), .cpu_dsack_n(cpu_dsack_n), .cpu_berr_n(cpu_berr_n),
    .cpu_data_oe(cpu_data_oe), .cpu_data_o(cpu_data_o), .obus_en(obus_en),
    .obus_dtack_n(obus_dtack_n), .obus_data(obus_data), .ide_irq(ide_irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: 0 idle, 1 waiting on old bus, 2 answering CPU, 3 bus error
  int         mst = 0;
  int         mcnt = 0;
  logic [2:0] ide_hist = 3'b000;
  logic [7:0] mbyte = 8'h00;

  function automatic bit bench_hit(input logic [31:0] a, input logic rw);
    return rw && (a[23:0] == 24'hFFFA01) && (a[31:24] == 8'h00 || a[31:24] == 8'hFF);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mst <= 0; mcnt <= 0; ide_hist <= 3'b000; mbyte <= 8'h00;
    end else begin
      ide_hist <= {ide_hist[1:0], ide_irq};
      case (mst)
        0: begin
          mcnt <= 0;
          if (!cpu_as_n && bench_hit(cpu_addr, cpu_rw)) mst <= 1;
        end
        1: begin
          if (cpu_as_n) mst <= 0;
          else if (!obus_dtack_n) begin
            mst <= 2;
            mbyte <= ide_hist[1] ? (obus_data & 8'hDF) : obus_data;
          end else if (mcnt == TMO - 1) mst <= 3;
          else mcnt <= mcnt + 1;
        end
        default: if (cpu_as_n) mst <= 0;
      endcase
    end
  end

  always @(negedge clk) begin
    #2;
    if (!done) begin
      string t;
      bit pass;
      pass = (mst == 0) && !cpu_as_n && !bench_hit(cpu_addr, cpu_rw);
      if (!rst_n) t = "R11";
      else if (mst == 1) t = "R4";
      else if (mst == 2) t = "R5";
      else if (mst == 3) t = "R9";
      else t = "R3";
      check({t, " obus_en"}, 32'(obus_en), 32'(pass || mst == 1));
      check({t, " dsack"}, 32'(cpu_dsack_n),
            pass ? 32'({1'b1, obus_dtack_n}) : (mst == 2 ? 32'd2 : 32'd3));
      check({t, " berr"}, 32'(cpu_berr_n), 32'(mst != 3));
      check({t == "R5" ? "R6" : t, " oe"}, 32'(cpu_data_oe), 32'(mst == 2));
      check(mst == 2 ? "R7 data" : "R6 data", cpu_data_o,
            mst == 2 ? {mbyte, 24'h0} : 32'h0);
    end
  end

  // One CPU access; exp_hit says whether interception is expected.
  task automatic access(input logic [31:0] a, input logic rw, input logic [7:0] d,
                        input int dly, input logic ide_v, input logic ide_flip,
                        input logic exp_hit, input string tag);
    logic [7:0] want;
    @(negedge clk); ide_irq = ide_v;
    repeat (3) @(negedge clk);
    cpu_as_n = 1'b0; cpu_addr = a; cpu_rw = rw; obus_data = d; obus_dtack_n = 1'b1;
    #3 check({tag, " first-cycle obus_en"}, 32'(obus_en), 32'(!exp_hit));
    repeat (dly) @(negedge clk);
    @(negedge clk); obus_dtack_n = 1'b0;
    if (ide_flip) ide_irq = ~ide_v;
    #3 if (!exp_hit) check({tag, " pass ack"}, 32'(cpu_dsack_n), 32'b10);
       else check("R4 ack hidden", 32'(cpu_dsack_n), 32'b11);
    @(negedge clk);
    if (exp_hit) begin
      want = ide_v ? (d & 8'hDF) : d;
      #3;
      check({tag, " R5 port8 ack"}, 32'(cpu_dsack_n), 32'b10);
      check("R5 isolated", 32'(obus_en), 32'd0);
      check({tag, " R7 byte"}, 32'(cpu_data_o[31:24]), 32'(want));
      check("R6 low lanes", 32'(cpu_data_o[23:0]), 32'd0);
    end
    @(negedge clk); cpu_as_n = 1'b1; obus_dtack_n = 1'b1;
    @(negedge clk);
    #3 check("R10 released", {29'd0, cpu_dsack_n, cpu_data_oe}, {29'd0, 2'b11, 1'b0});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #3 check("R11 reset dsack", 32'(cpu_dsack_n), 32'b11);
    check("R11 reset oe", 32'(cpu_data_oe), 32'd0);
    @(negedge clk); rst_n = 1'b1;

    access(32'h00FF8001, 1'b1, 8'h5A, 2, 1'b0, 1'b0, 1'b0, "R3");
    access(32'h00FFFA01, 1'b0, 8'h00, 1, 1'b1, 1'b0, 1'b0, "R2");
    access(32'h00FFFA01, 1'b1, 8'hE9, 0, 1'b0, 1'b0, 1'b1, "R1 R7");
    access(32'hFFFFFA01, 1'b1, 8'hFF, 3, 1'b1, 1'b0, 1'b1, "R1 alias");
    access(32'h01FFFA01, 1'b1, 8'hFF, 1, 1'b1, 1'b0, 1'b0, "R1 near-miss");
    access(32'h00FFFA01, 1'b1, 8'hD1, 2, 1'b0, 1'b0, 1'b1, "R7 bit5 low");
    access(32'h00FFFA01, 1'b1, 8'hD1, 0, 1'b1, 1'b0, 1'b1, "R7 both low");
    access(32'h00FFFA01, 1'b1, 8'hFF, 2, 1'b0, 1'b1, 1'b1, "R8 late rise");
    access(32'hFFFFFA01, 1'b1, 8'h3C, 1, 1'b1, 1'b1, 1'b1, "R8 late fall");
    for (int i = 0; i < 6; i++)
      access((i % 2) ? 32'hFFFFFA01 : 32'h00FFFA01, 1'b1, 8'(8'h17 * (i + 3)),
             i % 3, 1'(i / 2), 1'b0, 1'b1, "R7 sweep");

    // R9: silent peripheral
    @(negedge clk); cpu_as_n = 1'b0; cpu_addr = 32'h00FFFA01; cpu_rw = 1'b1;
    repeat (TMO + 1) @(negedge clk);
    #3 check("R9 berr", 32'(cpu_berr_n), 32'd0);
    check("R9 isolated", 32'(obus_en), 32'd0);
    @(negedge clk); cpu_as_n = 1'b1;
    @(negedge clk); #3 check("R10 berr released", 32'(cpu_berr_n), 32'd1);

    // R10: strobe dropped while waiting on the old bus
    @(negedge clk); cpu_as_n = 1'b0; cpu_addr = 32'hFFFFFA01;
    repeat (3) @(negedge clk);
    cpu_as_n = 1'b1;
    @(negedge clk); #3 check("R10 abort obus_en", 32'(obus_en), 32'd0);
    check("R10 abort dsack", 32'(cpu_dsack_n), 32'b11);
    repeat (3) @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule